// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is a parameterised general-purpose I/O port for a simple word-wide register bus. Software programs four control words: a direction mask where a one marks an input pin, an output latch, a per-pin open-drain enable and a per-pin digital-select mask. From these the block computes an output value and an output-enable for every pad. It also brings the pad levels through a synchronizer into a readable port word.

Pins that can serve an analog function start in analog mode after reset. While a pin is analog its driver is off and it reads back as zero. Pins listed as digital-only in a parameter mask always behave as digital pins. Register reads are combinational from the stored state. A read therefore reflects a direction change or a latch write in the cycle right after that write, with no extra wait.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the direction word (address 0) is all ones, the latch (address 2), open-drain (address 3) and digital-select (address 4) words are zero, and no pad output-enable is active.
- R2: A write to address 0, 2, 3 or 4 stores the full 16-bit word, which reads back unchanged. A write to the port address 1 loads the latch. Addresses 5 to 7 read as zero and writes to them change no register.
- R3: A digital pin with direction bit 1 has its output-enable off. A digital push-pull pin with direction bit 0 has its output-enable on and drives the latch bit.
- R4: For a digital output pin with its open-drain bit set, a latch 0 enables the driver with value 0, and a latch 1 turns the output-enable off. Such a pin is never driven high.
- R5: A pin that has an analog function and a digital-select bit of 0 has its output-enable off and reads 0 at the port address, whatever its pad level.
- R6: A pin outside the ANA_MASK parameter (default pins 12 to 15) acts as a digital pin whatever its digital-select bit.
- R7: A pad level that is steady before clock edge k appears in a digital input pin's port read after edge k+1, and not after edge k alone.
- R8: For a digital push-pull output pin, a port read in the cycle after a latch write returns the new latch bit. After a direction change to input, the port read in the next cycle returns the synchronized pad level.
- R9: A digital pin that is an input, or an open-drain output, reads its synchronized pad level at the port address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, zero when no read) |
| pad_in | input | 16 | Pad input levels (asynchronous) |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output-enable, 1 = driven |

## Verification
The pad logic is tried with latch patterns that mix ones and zeros across pins. The same pattern is run with all pins push-pull, with half the pins open-drain and with most pins analog. A wrong gating term then shows up in only some bit lanes. The port read is tried with pad levels that differ from the latch, which tells a read of the latch apart from a read of the pad. It is also sampled one and two edges after a pad change, which shows the synchronizer depth. A pad pattern of all ones on analog pins separates correct masking from a read that passes the pad through.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int GPIO_AW = 3;

   typedef enum logic [GPIO_AW-1:0] {
      REG_DIR  = 3'd0,
      REG_PORT = 3'd1,
      REG_LAT  = 3'd2,
      REG_ODE  = 3'd3,
      REG_DSEL = 3'd4
   } gpio_reg_e;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [GPIO_AW-1:0] addr,
   input  logic [WIDTH-1:0]   wdata,
   output logic [WIDTH-1:0]   dir_q,
   output logic [WIDTH-1:0]   lat_q,
   output logic [WIDTH-1:0]   ode_q,
   output logic [WIDTH-1:0]   dsel_q
);
   logic hit_dir, hit_lat, hit_ode, hit_dsel;

   always_comb begin
      hit_dir  = wr_en && (addr == REG_DIR);
      hit_lat  = wr_en && ((addr == REG_LAT) || (addr == REG_PORT));
      hit_ode  = wr_en && (addr == REG_ODE);
      hit_dsel = wr_en && (addr == REG_DSEL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '1;
         lat_q  <= '0;
         ode_q  <= '0;
         dsel_q <= '0;
      end else begin
         if (hit_dir)  dir_q  <= wdata;
         if (hit_lat)  lat_q  <= wdata;
         if (hit_ode)  ode_q  <= wdata;
         if (hit_dsel) dsel_q <= wdata;
      end
   end

   // R1: reset leaves every pin an input
   p_reset_inputs_r1: assert property (@(posedge clk) !rst_n |=> (dir_q == '1));

   // R2: direction write stores the full word
   p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_DIR) |=> (dir_q == $past(wdata)));

   // R2: a port-address write lands in the latch
   p_port_write_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_PORT) |=> (lat_q == $past(wdata)));

   // R2: unmapped addresses leave the latch untouched
   p_unmapped_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr > REG_DSEL) |=> $stable(lat_q) && $stable(dir_q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[0] <= '0;
               else        stage_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] lat_q,
   input  logic [WIDTH-1:0] ode_q,
   input  logic [WIDTH-1:0] dig,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe
);
   genvar i;
   generate
      for (i = 0; i < WIDTH; i++) begin : g_pin
         logic drive_req;
         always_comb begin
            drive_req = dig[i] && !dir_q[i];
            if (ode_q[i]) begin
               pad_out[i] = 1'b0;
               pad_oe[i]  = drive_req && !lat_q[i];
            end else begin
               pad_out[i] = lat_q[i];
               pad_oe[i]  = drive_req;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int          WIDTH       = 16,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] ANA_MASK    = 16'h0FFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [GPIO_AW-1:0] bus_addr,
   input  logic [WIDTH-1:0]   bus_wdata,
   output logic [WIDTH-1:0]   bus_rdata,
   input  logic [WIDTH-1:0]   pad_in,
   output logic [WIDTH-1:0]   pad_out,
   output logic [WIDTH-1:0]   pad_oe
);
   localparam logic [WIDTH-1:0] ANA_PINS = WIDTH'(ANA_MASK);

   generate
      if (WIDTH < 1 || WIDTH > 16) begin : g_bad_width
         $error("gpio_port_ctrl: WIDTH must be 1 to 16");
      end
   endgenerate

   logic [WIDTH-1:0] dir_q, lat_q, ode_q, dsel_q;
   logic [WIDTH-1:0] dig, sync_q, port_val;
   logic             wr_en, rd_en;

   assign wr_en = bus_sel && bus_wr;
   assign rd_en = bus_sel && !bus_wr;
   assign dig   = dsel_q | ~ANA_PINS;

   gpio_regfile #(.WIDTH(WIDTH)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .dir_q  (dir_q),
      .lat_q  (lat_q),
      .ode_q  (ode_q),
      .dsel_q (dsel_q)
   );

   gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in & dig),
      .dout  (sync_q)
   );

   gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pads (
      .dir_q   (dir_q),
      .lat_q   (lat_q),
      .ode_q   (ode_q),
      .dig     (dig),
      .pad_out (pad_out),
      .pad_oe  (pad_oe)
   );

   always_comb begin
      for (int i = 0; i < WIDTH; i++) begin
         if (!dig[i])                      port_val[i] = 1'b0;
         else if (!dir_q[i] && !ode_q[i]) port_val[i] = lat_q[i];
         else                              port_val[i] = sync_q[i];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_en) begin
         unique case (bus_addr)
            REG_DIR:  bus_rdata = dir_q;
            REG_PORT: bus_rdata = port_val;
            REG_LAT:  bus_rdata = lat_q;
            REG_ODE:  bus_rdata = ode_q;
            REG_DSEL: bus_rdata = dsel_q;
            default:  bus_rdata = '0;
         endcase
      end
   end

   // R3: input pins never drive
   p_input_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & dir_q) == '0));

   // R4: an open-drain pin never drives a one
   p_od_never_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & pad_out & ode_q) == '0));

   // R5: analog pins have no driver
   p_analog_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~dig) == '0));

   // R5: analog pins read zero at the port address
   p_analog_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && bus_addr == REG_PORT) |-> ((bus_rdata & ~dig) == '0));
endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] pad_in = 16'hFFFF;
   logic [15:0] pad_out, pad_oe;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_port_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      #1;
      check("R1 oe at reset", pad_oe, 16'h0000);
      bus_read(3'd0, v); check("R1 dir reset", v, 16'hFFFF);
      bus_read(3'd2, v); check("R1 lat reset", v, 16'h0000);
      bus_read(3'd3, v); check("R1 ode reset", v, 16'h0000);
      bus_read(3'd4, v); check("R1 dsel reset", v, 16'h0000);
      bus_read(3'd1, v); check("R6 R5 port at reset", v, 16'hF000);
   endtask

   task automatic t_regs();
      logic [15:0] v;
      bus_write(3'd0, 16'hA5A5); bus_read(3'd0, v); check("R2 dir rw", v, 16'hA5A5);
      bus_write(3'd3, 16'h1234); bus_read(3'd3, v); check("R2 ode rw", v, 16'h1234);
      bus_write(3'd4, 16'hC3C3); bus_read(3'd4, v); check("R2 dsel rw", v, 16'hC3C3);
      bus_write(3'd1, 16'h5A5A); bus_read(3'd2, v); check("R2 port write to lat", v, 16'h5A5A);
      bus_write(3'd2, 16'h0F0F); bus_read(3'd2, v); check("R2 lat rw", v, 16'h0F0F);
      bus_write(3'd5, 16'hFFFF); bus_write(3'd7, 16'h0000);
      bus_read(3'd5, v); check("R2 unmapped reads zero", v, 16'h0000);
      bus_read(3'd0, v); check("R2 unmapped write dir kept", v, 16'hA5A5);
      bus_read(3'd2, v); check("R2 unmapped write lat kept", v, 16'h0F0F);
      bus_read(3'd4, v); check("R2 unmapped write dsel kept", v, 16'hC3C3);
   endtask

   task automatic t_push_pull();
      logic [15:0] v;
      pad_in = 16'h0000;
      bus_write(3'd4, 16'hFFFF);
      bus_write(3'd3, 16'h0000);
      bus_write(3'd0, 16'hFF00);
      bus_write(3'd2, 16'h3C3C);
      #1;
      check("R3 oe push-pull half", pad_oe, 16'h00FF);
      check("R3 out value", pad_out, 16'h3C3C);
      bus_write(3'd0, 16'h0000);
      bus_write(3'd2, 16'hC3A5);
      bus_read(3'd1, v); check("R8 port next cycle after lat write", v, 16'hC3A5);
      check("R3 oe all outputs", pad_oe, 16'hFFFF);
      bus_write(3'd0, 16'h00FF);
      bus_read(3'd1, v); check("R8 dir change to input reads pad", v, 16'hC300);
   endtask

   task automatic t_open_drain();
      logic [15:0] v;
      bus_write(3'd0, 16'h0000);
      bus_write(3'd3, 16'h00FF);
      bus_write(3'd2, 16'h0F0F);
      pad_in = 16'h0055;
      #1;
      check("R4 oe with od", pad_oe, 16'hFFF0);
      check("R4 out with od", pad_out, 16'h0F00);
      repeat (2) @(negedge clk);
      bus_read(3'd1, v); check("R9 od pins read pad", v, 16'h0F55);
   endtask

   task automatic t_analog();
      logic [15:0] v;
      bus_write(3'd3, 16'h0000);
      bus_write(3'd0, 16'h0000);
      bus_write(3'd2, 16'hFFFF);
      bus_write(3'd4, 16'h0000);
      pad_in = 16'hFFFF;
      #1;
      check("R5 R6 oe analog", pad_oe, 16'hF000);
      repeat (2) @(negedge clk);
      bus_read(3'd1, v); check("R5 analog outputs read zero", v, 16'hF000);
      bus_write(3'd0, 16'hFFFF);
      repeat (2) @(negedge clk);
      bus_read(3'd1, v); check("R5 analog inputs ignore pad", v, 16'hF000);
      bus_write(3'd0, 16'h0000);
      bus_write(3'd4, 16'h00FF);
      #1;
      check("R5 partial digital oe", pad_oe, 16'hF0FF);
   endtask

   task automatic t_sync();
      logic [15:0] v;
      bus_write(3'd4, 16'hFFFF);
      bus_write(3'd0, 16'hFFFF);
      pad_in = 16'h0000;
      repeat (3) @(negedge clk);
      pad_in = 16'hBEEF;
      bus_read(3'd1, v); check("R7 one edge not yet", v, 16'h0000);
      bus_read(3'd1, v); check("R7 two edges visible", v, 16'hBEEF);
      check("R3 inputs undriven", pad_oe, 16'h0000);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_push_pull();
      t_open_drain();
      t_analog();
      t_sync();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule